// File: doc/BRIEF.md
# Slotted Audio-Codec Serial Framer

The framer runs a fixed serial frame of 256 bit-clock cycles. Each frame holds a 16-bit tag slot followed by twelve 20-bit data slots. On the bit clock it drives a frame-sync output. It shifts transmit words out most-significant bit first and gathers the received bits into words. Words reach the block through a one-word transmit holding register and leave it through a one-word receive register, each with a simple handshake.

A 2-bit mode input picks one of two ways to map words onto the frame.

- **Aligned mode:** every word is 16 bits and corresponds to exactly one slot. The tag slot carries a full word. A 20-bit data slot carries the word followed by four zero bits, and on receive its four trailing bits are discarded.
- **Packed mode:** the frame is cut into sixteen consecutive 16-bit chunks with no regard for slot edges. Every frame bit therefore travels. The frame also splits into four 64-bit segments, and software tracks them with a pulse at the end of each segment and a segment index.

The mode is taken at the start of each frame. A mode with its upper bit clear stops the link.

Top module: `aclink_framer`

## Requirements
- R1: A frame lasts 256 bit-clock cycles. Bit 0 of the first frame occupies the cycle after the first rising edge at which the mode is valid (mode[1] = 1). Frames follow one another without a gap while the mode stays valid.
- R2: `fsync` is high during bits 0 to 15 of each frame and low during bits 16 to 255.
- R3: In aligned mode (mode = 2'b10), the tag slot (bits 0-15) is delivered as one 16-bit word. Each 20-bit slot starting at bit 16+20k delivers its first 16 received bits as a word, and its last 4 bits are dropped.
- R4: In aligned mode, each transmit word goes out in its slot MSB first. In a 20-bit slot the word is followed by 4 zero bits.
- R5: In aligned mode, each frame moves exactly 13 words in each direction, one per slot, in slot order.
- R6: In packed mode (mode = 2'b11), frame bits 16k to 16k+15 form word k for k = 0 to 15 in both directions, so all 256 bits are carried.
- R7: With mode[1] = 0 (2'b00 or 2'b01), the link is stopped. `fsync` and `sdo` stay low, no segment pulse is made, and no word is received. The mode is sampled only when a frame begins.
- R8: In packed mode, `seg_done` pulses for one cycle in the cycle after frame bits 63, 127, 191 and 255, and `seg_idx` equals the current bit number divided by 64. In aligned mode, `seg_done` pulses once after bit 255 and `seg_idx` is 0.
- R9: Words are serialised MSB first. `sdo` changes after the rising edge of `bclk`, and `sdi` is sampled on the falling edge inside the same bit cycle.
- R10: If a transmit word is due and the holding register is empty, the word is sent as zeros and `tx_underflow` is set. It stays set until reset.
- R11: If a received word completes while `rx_full` is set and `rx_take` is low, the new word is discarded, `rx_data` keeps its value, and `rx_overflow` is set until reset.
- R12: `tx_ready` is high exactly when the holding register is empty. A word is accepted on a rising edge with `tx_valid` and `tx_ready` high. `rx_take` on a rising edge clears `rx_full` unless a new word lands on that edge. After reset, `tx_ready` = 1 and `rx_full` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 2'b10 aligned, 2'b11 packed, others stopped |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 16 | Last received word |
| rx_full | output | 1 | `rx_data` holds an untaken word |
| rx_take | input | 1 | Consume the received word |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| fsync | output | 1 | Frame sync |
| seg_done | output | 1 | End-of-segment (packed) or end-of-frame (aligned) pulse |
| seg_idx | output | 2 | Current 64-bit segment in packed mode |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_overflow | output | 1 | Sticky receive overflow |

## Verification
The assertions watch properties that hold on every cycle:
- the counter wraps straight into a new frame;
- sync rises only on bit 0;
- the four pad bits of aligned 20-bit slots are zero on the wire;
- a held transmit word is never lost;
- an overflowing receive word leaves the register untouched;
- both error flags stay set.

Only the bench's scenarios can show that words map to the right frame bits in each mode, which needs a model of the whole bit stream. This covers loopback in both modes, the truncation of a known received pattern, the segment pulse positions, and the stopped modes.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int NSLOT   = 12;
  localparam int WORD_W  = 16;
  localparam int SEG_W   = 64;
  localparam int FRAME_W = TAG_W + NSLOT * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int PAD_W   = SLOT_W - WORD_W;
  localparam int SEGS    = FRAME_W / SEG_W;
  localparam int SEG_IW  = $clog2(SEGS);

  // last bit of a word in the current layout
  function automatic logic word_last(input logic pk, input logic [CNT_W-1:0] c);
    int ci;
    ci = int'(c);
    if (pk) return (ci % WORD_W) == WORD_W - 1;
    if (ci < TAG_W) return ci == TAG_W - 1;
    return ((ci - TAG_W) % SLOT_W) == SLOT_W - 1;
  endfunction

  // zero-fill position inside an aligned 20-bit slot
  function automatic logic pad_bit(input logic pk, input logic [CNT_W-1:0] c);
    int ci;
    ci = int'(c);
    if (pk || ci < TAG_W) return 1'b0;
    return ((ci - TAG_W) % SLOT_W) >= WORD_W;
  endfunction

  // last bit of a segment (packed) or of the frame (aligned)
  function automatic logic seg_last(input logic pk, input logic [CNT_W-1:0] c);
    int ci;
    ci = int'(c);
    if (pk) return (ci % SEG_W) == SEG_W - 1;
    return ci == FRAME_W - 1;
  endfunction

  // choose the kept bits of a completed received word
  function automatic logic [WORD_W-1:0] rx_pick(input logic pk, input logic [CNT_W-1:0] c,
                                                input logic [SLOT_W-1:0] v);
    if (pk || int'(c) < TAG_W) return v[WORD_W-1:0];
    return v[SLOT_W-1:PAD_W];
  endfunction
endpackage

// File: rtl/aclink_timer.sv
module aclink_timer
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  output logic              run_o,
  output logic              pk_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              load_o,
  output logic              fsync_o,
  output logic              done_o,
  output logic [SEG_IW-1:0] seg_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(TAG_W);

  logic run_q, pk_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic valid;

  assign valid = mode_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pk_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q && seg_last(pk_q, cnt_q);
      if (!valid) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        pk_q  <= mode_i[0];
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        pk_q  <= mode_i[0];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign pk_o    = pk_q;
  assign cnt_o   = cnt_q;
  assign load_o  = valid && (!run_q || word_last(pk_q, cnt_q));
  assign fsync_o = run_q && (cnt_q < SYNC_END);
  assign done_o  = done_q;
  assign seg_o   = (run_q && pk_q) ? cnt_q[CNT_W-1 -: SEG_IW] : '0;

  // R1: a valid frame end flows into bit 0 of the next frame
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && valid && cnt_q == LAST |=> run_q && cnt_q == '0);
  // R2: sync only rises on bit 0
  a_r2_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> cnt_q == '0);
  // R8: segment pulse only follows a running cycle
  a_r8_done_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(run_q));
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              pk_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              sdo_o,
  output logic              underflow_o
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_full;
  logic [SLOT_W-1:0] sh_q;
  logic              unf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      unf_q     <= 1'b0;
    end else begin
      if (tx_valid_i && !hold_full) begin
        hold_q    <= tx_data_i;
        hold_full <= 1'b1;
      end else if (load_i) begin
        hold_full <= 1'b0;
      end
      if (load_i) begin
        if (hold_full) sh_q <= {hold_q, {PAD_W{1'b0}}};
        else begin
          sh_q  <= '0;
          unf_q <= 1'b1;
        end
      end else if (run_i) begin
        sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
      end else begin
        sh_q <= '0;
      end
    end
  end

  assign tx_ready_o  = !hold_full;
  assign sdo_o       = run_i && sh_q[SLOT_W-1];
  assign underflow_o = unf_q;

  // R4: pad positions of aligned 20-bit slots are zero on the wire
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && pad_bit(pk_i, cnt_i) |-> !sdo_o);
  // R10: underflow flag is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q);
  // R12: a held word waits untouched until a slot takes it
  a_r12_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !load_i |=> hold_full && $stable(hold_q));
endmodule

// File: rtl/aclink_rx.sv
module aclink_rx
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              pk_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sdi_i,
  input  logic              rx_take_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              overflow_o
);
  logic              sdi_q;
  logic [SLOT_W-1:0] sh_q;
  logic [SLOT_W-1:0] sh_in;
  logic [WORD_W-1:0] data_q;
  logic              full_q, ovf_q;
  logic              wdone, blocked;

  // falling-edge sample of the serial input
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdi_q <= 1'b0;
    else        sdi_q <= sdi_i;
  end

  assign sh_in   = {sh_q[SLOT_W-2:0], sdi_q};
  assign wdone   = run_i && word_last(pk_i, cnt_i);
  assign blocked = full_q && !rx_take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      sh_q <= run_i ? sh_in : '0;
      if (wdone && !blocked) begin
        data_q <= rx_pick(pk_i, cnt_i, sh_in);
        full_q <= 1'b1;
      end else if (rx_take_i) begin
        full_q <= 1'b0;
      end
      if (wdone && blocked) ovf_q <= 1'b1;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_full_o  = full_q;
  assign overflow_o = ovf_q;

  // R11: a word arriving at a full register is dropped and flagged
  a_r11_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    wdone && full_q && !rx_take_i |=> $stable(data_q) && ovf_q);
  // R11: overflow flag is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/aclink_framer.sv
module aclink_framer
  import aclink_pkg::*;
(
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  input  logic              rx_take,
  output logic              sdo,
  input  logic              sdi,
  output logic              fsync,
  output logic              seg_done,
  output logic [SEG_IW-1:0] seg_idx,
  output logic              tx_underflow,
  output logic              rx_overflow
);
  logic             run, pk, load;
  logic [CNT_W-1:0] cnt;

  aclink_timer u_timer (
    .clk(bclk), .rst_n(rst_n), .mode_i(mode),
    .run_o(run), .pk_o(pk), .cnt_o(cnt), .load_o(load),
    .fsync_o(fsync), .done_o(seg_done), .seg_o(seg_idx)
  );

  aclink_tx u_tx (
    .clk(bclk), .rst_n(rst_n), .run_i(run), .pk_i(pk), .cnt_i(cnt),
    .load_i(load), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .sdo_o(sdo), .underflow_o(tx_underflow)
  );

  aclink_rx u_rx (
    .clk(bclk), .rst_n(rst_n), .run_i(run), .pk_i(pk), .cnt_i(cnt),
    .sdi_i(sdi), .rx_take_i(rx_take), .rx_data_o(rx_data),
    .rx_full_o(rx_full), .overflow_o(rx_overflow)
  );

  // R7: a stopped link keeps sync and data low
  a_r7_idle_quiet: assert property (@(posedge bclk) disable iff (!rst_n)
    !run |-> !fsync && !sdo);
endmodule

// File: tb/tb_aclink_framer.sv
module tb_aclink_framer;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        rx_take = 1'b0;
  logic        sdi = 1'b0;
  wire         tx_ready, rx_full, sdo, fsync, seg_done, tx_underflow, rx_overflow;
  wire [15:0]  rx_data;
  wire [1:0]   seg_idx;

  aclink_framer dut (
    .bclk(bclk), .rst_n(rst_n), .mode(mode), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_full(rx_full), .rx_take(rx_take),
    .sdo(sdo), .sdi(sdi), .fsync(fsync), .seg_done(seg_done), .seg_idx(seg_idx),
    .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
  );

  always #5 bclk = ~bclk;

  int vecs = 0, errs = 0, cyc = 0;
  int running = 0, bidx = 0, pk = 0, start_pend = 0, stop_pend = 0, pend_pk = 0;
  int loopb = 0, feed = 1, take = 1, zero_tx = 0;
  int rx_n = 0, tx_n = 0, tx_acc = 0;

  function automatic int genbit(int b);
    return ((b * 5) ^ (b >> 2) ^ (b >> 5) ^ 1) & 1;
  endfunction

  function automatic int txw(int i);
    return ((i * 941) ^ 'hC3E1) & 'hFFFF;
  endfunction

  // frame bits start..start+15, first bit as MSB
  function automatic int gen_word(int p, int k);
    int s;
    int w;
    w = 0;
    s = p != 0 ? 16 * k : (k == 0 ? 0 : 16 + 20 * (k - 1));
    for (int j = 0; j < 16; j++) w = (w << 1) | genbit(s + j);
    return w;
  endfunction

  function automatic int exp_rx(int k);
    return loopb != 0 ? txw(k) : gen_word(pk, k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  task automatic cycle();
    int pr, pb, pp, ed, es, ef;
    @(posedge bclk);
    #1;
    cyc++;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL R1 watchdog: actual %0d expected below %0d", cyc, 20000);
      finish_run();
    end
    pr = running; pb = bidx; pp = pk;
    if (start_pend != 0) begin running = 1; bidx = 0; pk = pend_pk; start_pend = 0; end
    else if (stop_pend != 0) begin running = 0; stop_pend = 0; end
    else if (running != 0) bidx = (bidx + 1) % 256;
    // R2 sync window
    ef = (running != 0 && bidx < 16) ? 1 : 0;
    chk(int'(fsync) == ef, "R2", "fsync", int'(fsync), ef);
    // R8 pulse after segment or frame end
    ed = (pr != 0 && ((pp != 0) ? (pb % 64 == 63) : (pb == 255))) ? 1 : 0;
    chk(int'(seg_done) == ed, "R8", "seg_done", int'(seg_done), ed);
    es = (running != 0 && pk != 0) ? bidx / 64 : 0;
    chk(int'(seg_idx) == es, "R8", "seg_idx", int'(seg_idx), es);
    if (running == 0) chk(sdo == 1'b0, "R7", "sdo idle", int'(sdo), 0);
    else if (zero_tx != 0 && bidx >= 16) chk(sdo == 1'b0, "R10", "sdo underflow", int'(sdo), 0);
    else if (pk == 0 && bidx >= 16 && (bidx - 16) % 20 >= 16)
      chk(sdo == 1'b0, "R4", "sdo pad", int'(sdo), 0);
    // R12 transmit handshake
    if (tx_acc != 0) tx_n++;
    tx_acc = (feed != 0 && tx_ready) ? 1 : 0;
    tx_valid = feed != 0;
    tx_data = 16'(txw(tx_n));
    // receive side; R9 MSB-first ordering is implied by the word model
    rx_take = 1'b0;
    if (rx_full && take != 0) begin
      chk(int'(rx_data) == exp_rx(rx_n), pk != 0 ? "R6" : (loopb != 0 ? "R5" : "R3"),
          "rx word", int'(rx_data), exp_rx(rx_n));
      rx_n++;
      rx_take = 1'b1;
    end
    sdi = (loopb != 0) ? sdo : genbit(bidx) != 0;
  endtask

  task automatic run_phase(input logic [1:0] m, input int frames, input int lp, input int fd,
                           input int tk, input int zt);
    int nexp;
    rst_n = 1'b0; mode = 2'b00; tx_valid = 1'b0; rx_take = 1'b0;
    running = 0; start_pend = 0; stop_pend = 0; tx_n = 0; tx_acc = 0; rx_n = 0;
    loopb = lp; take = tk; zero_tx = 0; feed = 1;
    repeat (3) @(posedge bclk);
    #1 rst_n = 1'b1;
    repeat (4) cycle();
    chk(tx_ready == 1'b0, "R12", "tx_ready after preload", int'(tx_ready), 0);
    feed = fd; zero_tx = zt; mode = m;
    if (m[1]) begin start_pend = 1; pend_pk = int'(m[0]); end
    repeat (frames * 256) cycle();
    mode = 2'b00;
    if (running != 0 || start_pend != 0) stop_pend = 1;
    repeat (8) cycle();
    nexp = m[1] ? frames * (m[0] ? 16 : 13) : 0;
    if (tk != 0) begin
      chk(rx_n == nexp, m[1] ? (m[0] ? "R6" : "R5") : "R7", "word count", rx_n, nexp);
      chk(rx_overflow == 1'b0, "R11", "no overflow", int'(rx_overflow), 0);
    end
    chk(int'(tx_underflow) == zt, "R10", "underflow flag", int'(tx_underflow), zt);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(posedge bclk);
    #1;
    // R12 reset state
    chk(tx_ready == 1'b1, "R12", "reset tx_ready", int'(tx_ready), 1);
    chk(rx_full == 1'b0, "R12", "reset rx_full", int'(rx_full), 0);
    chk(fsync == 1'b0 && sdo == 1'b0, "R7", "reset lines", int'({fsync, sdo}), 0);
    chk(tx_underflow == 1'b0 && rx_overflow == 1'b0, "R10", "reset flags",
        int'({tx_underflow, rx_overflow}), 0);
    run_phase(2'b10, 2, 1, 1, 1, 0);  // R5 aligned loopback
    run_phase(2'b11, 2, 1, 1, 1, 0);  // R6 packed loopback
    run_phase(2'b10, 1, 0, 1, 1, 0);  // R3 truncation of known pattern
    run_phase(2'b11, 1, 0, 1, 1, 0);  // R6 packed known pattern
    run_phase(2'b10, 1, 0, 0, 1, 1);  // R10 underflow
    run_phase(2'b11, 1, 0, 1, 0, 0);  // R11 overflow, nothing taken
    chk(rx_full == 1'b1, "R11", "still full", int'(rx_full), 1);
    chk(int'(rx_data) == gen_word(1, 0), "R11", "old word kept", int'(rx_data), gen_word(1, 0));
    chk(rx_overflow == 1'b1, "R11", "overflow flag", int'(rx_overflow), 1);
    take = 1;
    repeat (2) cycle();
    chk(rx_full == 1'b0, "R12", "take clears full", int'(rx_full), 0);
    run_phase(2'b01, 1, 0, 1, 1, 0);  // R7 stopped mode
    finish_run();
  end
endmodule